// File: doc/BRIEF.md
# SPI Register Target with Address Auto-Increment

This block is the serial front end of a small register file. An SPI controller frames each transaction with an active-low chip select and clocks a command byte followed by one or more data bytes. The command byte gives the direction, whether the address advances between bytes, and a 6-bit register address. Write bytes are passed to the register bus as single-cycle write strobes. Read bytes are fetched over the same bus and shifted out on the serial output.

The block runs on the system clock. It samples the serial pins through a short synchronizer, so the SPI clock must be several times slower than the system clock. A configuration input selects the input line. In 4-wire mode commands and write data arrive on the dedicated input. In 3-wire mode they arrive on the shared line. In both modes read data leaves on one output, and a tri-state enable tells the pad ring when to drive the line.

Burst reads with auto-increment treat the six-byte sample window (addresses 0x28 to 0x2D: X, Y and Z, low byte then high byte) as a ring. This lets a host poll all three axes again and again without re-addressing.

Top module: `spi_regslave`

## Requirements
- R1: After reset, and whenever chip select is high, the output enable is low and neither register strobe fires, even if the serial clock toggles.
- R2: The first bit clocked in after chip select falls is the direction (1 = read). The second is the increment flag (1 = advance). The next six bits are the register address, MSB first.
- R3: Each complete write data byte, taken MSB first on rising serial clock edges, produces exactly one `reg_wr` pulse. The pulse carries that byte and the current address.
- R4: Read data is sent MSB first. Each bit changes on a falling serial clock edge, so the first bit of every byte is valid before the first rising edge of that byte.
- R5: With the increment flag at 0, every data byte of the transaction uses the address from the command byte.
- R6: With the increment flag at 1, the address advances by one after every data byte.
- R7: In an incrementing read, the byte after address 0x2D comes from address 0x28.
- R8: With `cfg_three_wire` = 1, command and write bits are taken from `spi_sdio_in` and `spi_sdi` is ignored. With 0 the roles are swapped.
- R9: `spi_sdo_oe` is high during the data phase of a read and low during any write.
- R10: If chip select rises part-way through a write data byte, no write is issued and the addressed register keeps its value.
- R11: In an incrementing write the address does not wrap at 0x2D. The byte after 0x2D goes to 0x2E.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_three_wire | input | 1 | 1 selects 3-wire mode (input taken from the shared line) |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, idles high |
| spi_sdi | input | 1 | Serial data input, 4-wire mode |
| spi_sdio_in | input | 1 | Input side of the shared data line, 3-wire mode |
| spi_sdo | output | 1 | Serial read data |
| spi_sdo_oe | output | 1 | Output enable for the data pad |
| reg_addr | output | 6 | Register bus address |
| reg_wr | output | 1 | Register write strobe, one cycle |
| reg_wdata | output | 8 | Register write data |
| reg_rd | output | 1 | Register read strobe, one cycle, read data sampled in the same cycle |
| reg_rdata | input | 8 | Register read data for `reg_addr` |

## Verification
The assertions watch, on every cycle, the properties that need no knowledge of the bit stream. These are: a quiet bus and an undriven pad while chip select has been high, write strobes that last a single cycle, reads and writes that never coincide, and an output enable that stays low while a write is being committed. Only the bench scenarios can show the data-dependent behaviour. That covers how the command bits are decoded, the address sequence for fixed, incrementing and wrapping bursts, the selection of the input line in each mode, and the loss of a cut-off write byte. The bench checks these against its own register model.

// File: rtl/spi_regslave_pkg.sv
package spi_regslave_pkg;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 8;

    typedef enum logic {
        PH_CMD  = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

    typedef struct packed {
        logic              rd;
        logic              inc;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    // Address after a data byte; wrap_en applies the window ring (reads only)
    function automatic logic [ADDR_W-1:0] next_addr(
        input logic [ADDR_W-1:0] cur,
        input logic              inc,
        input logic              wrap_en,
        input logic [ADDR_W-1:0] win_lo,
        input logic [ADDR_W-1:0] win_hi
    );
        if (!inc)
            return cur;
        else if (wrap_en && cur == win_hi)
            return win_lo;
        else
            return cur + 1'b1;
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int              STAGES  = 2,
    parameter int              W       = 1,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                chain[s] <= RST_VAL;
            else if (s == 0)
                chain[s] <= d;
            else
                chain[s] <= chain[(s == 0) ? 0 : s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         active,
    input  logic         sample,
    input  logic         din,
    output logic         done,
    output logic [W-1:0] byte_o
);
    localparam int CW = $clog2(W);

    logic [CW-1:0] cnt;
    logic [W-1:0]  sh;
    logic [W-1:0]  sh_next;

    assign sh_next = {sh[W-2:0], din};

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt  <= '0;
            sh   <= '0;
            done <= 1'b0;
            if (rst) byte_o <= '0;
        end else begin
            done <= 1'b0;
            if (sample) begin
                sh <= sh_next;
                if (cnt == CW'(W-1)) begin
                    cnt    <= '0;
                    done   <= 1'b1;
                    byte_o <= sh_next;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] ldata,
    input  logic         shift,
    output logic         dout
);
    logic [W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            dout <= 1'b0;
        end else if (load) begin
            sh <= ldata;
        end else if (shift) begin
            dout <= sh[W-1];
            sh   <= {sh[W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/spi_regslave.sv
module spi_regslave
    import spi_regslave_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] WIN_LO      = 6'h28,
    parameter logic [ADDR_W-1:0] WIN_HI      = 6'h2D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_three_wire,
    input  logic              spi_cs_n,
    input  logic              spi_sclk,
    input  logic              spi_sdi,
    input  logic              spi_sdio_in,
    output logic              spi_sdo,
    output logic              spi_sdo_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_rd,
    input  logic [DATA_W-1:0] reg_rdata
);
    logic              cs_s, sclk_s, din_s, sclk_prev;
    logic              active, rise, fall;
    logic              done;
    logic [DATA_W-1:0] rx_byte;
    phase_e            phase;
    cmd_t              cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic              load_pend, wr_pend;
    logic [DATA_W-1:0] wdata_q;
    logic              rd_data_phase;

    // Mode select picks the input line before synchronization
    spi_pin_sync #(.STAGES(SYNC_STAGES), .W(2), .RST_VAL(2'b11)) u_sync_ctl (
        .clk(clk), .rst(rst),
        .d({spi_cs_n, spi_sclk}),
        .q({cs_s, sclk_s})
    );

    spi_pin_sync #(.STAGES(SYNC_STAGES), .W(1), .RST_VAL(1'b0)) u_sync_dat (
        .clk(clk), .rst(rst),
        .d(cfg_three_wire ? spi_sdio_in : spi_sdi),
        .q(din_s)
    );

    always_ff @(posedge clk) begin
        if (rst) sclk_prev <= 1'b1;
        else     sclk_prev <= sclk_s;
    end

    assign active = ~cs_s;
    assign rise   = active &  sclk_s & ~sclk_prev;
    assign fall   = active & ~sclk_s &  sclk_prev;

    spi_rx_shift #(.W(DATA_W)) u_rx (
        .clk(clk), .rst(rst),
        .active(active), .sample(rise), .din(din_s),
        .done(done), .byte_o(rx_byte)
    );

    // Transaction control: command decode, address sequencing, bus strobes
    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_CMD;
            cmd_q     <= '0;
            addr_q    <= '0;
            load_pend <= 1'b0;
            wr_pend   <= 1'b0;
            wdata_q   <= '0;
        end else begin
            load_pend <= 1'b0;
            wr_pend   <= 1'b0;
            if (wr_pend)
                addr_q <= next_addr(addr_q, cmd_q.inc, 1'b0, WIN_LO, WIN_HI);
            if (!active) begin
                phase    <= PH_CMD;
                cmd_q.rd <= 1'b0;
            end else if (done) begin
                if (phase == PH_CMD) begin
                    cmd_q     <= cmd_t'(rx_byte);
                    addr_q    <= rx_byte[ADDR_W-1:0];
                    phase     <= PH_DATA;
                    load_pend <= rx_byte[DATA_W-1];
                end else if (cmd_q.rd) begin
                    addr_q    <= next_addr(addr_q, cmd_q.inc, 1'b1, WIN_LO, WIN_HI);
                    load_pend <= 1'b1;
                end else begin
                    wr_pend <= 1'b1;
                    wdata_q <= rx_byte;
                end
            end
        end
    end

    assign rd_data_phase = active && (phase == PH_DATA) && cmd_q.rd;

    spi_tx_shift #(.W(DATA_W)) u_tx (
        .clk(clk), .rst(rst),
        .load(load_pend), .ldata(reg_rdata),
        .shift(fall && rd_data_phase),
        .dout(spi_sdo)
    );

    assign spi_sdo_oe = rd_data_phase;
    assign reg_addr   = addr_q;
    assign reg_wr     = wr_pend;
    assign reg_wdata  = wdata_q;
    assign reg_rd     = load_pend;
endmodule

// File: rtl/spi_regslave_checker.sv
module spi_regslave_checker (
    input logic clk,
    input logic rst,
    input logic spi_cs_n,
    input logic spi_sdo_oe,
    input logic reg_wr,
    input logic reg_rd
);
    // R1: chip select held high for three samples -> pad undriven, no strobes
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2)) |-> (!spi_sdo_oe && !reg_wr));

    // R3: one write strobe per byte
    assert_wr_single_R3: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> !reg_wr);

    // R9: a read fetch never coincides with a write commit
    assert_rd_wr_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_rd));

    // R9: pad not driven while a write is committed
    assert_no_drive_on_write_R9: assert property (@(posedge clk) disable iff (rst)
        reg_wr |-> !spi_sdo_oe);
endmodule

bind spi_regslave spi_regslave_checker u_chk (
    .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_sdo_oe(spi_sdo_oe),
    .reg_wr(reg_wr), .reg_rd(reg_rd)
);

// File: tb/spi_regslave_test.sv
module spi_regslave_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int WATCHDOG   = 150000;

    typedef struct packed {
        logic       tw;
        logic       rd;
        logic       inc;
        logic [5:0] addr;
        logic [3:0] n;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b1, 6'h28, 4'd6},
        '{1'b0, 1'b1, 1'b1, 6'h28, 4'd8},
        '{1'b0, 1'b1, 1'b0, 6'h05, 4'd3},
        '{1'b1, 1'b0, 1'b0, 6'h12, 4'd2},
        '{1'b1, 1'b1, 1'b1, 6'h10, 4'd4},
        '{1'b0, 1'b0, 1'b1, 6'h2C, 4'd3},
        '{1'b1, 1'b1, 1'b1, 6'h2C, 4'd3}
    };

    logic       clk = 0;
    logic       rst = 1;
    logic       cfg_three_wire = 0;
    logic       spi_cs_n = 1, spi_sclk = 1, spi_sdi = 0, spi_sdio_in = 0;
    logic       spi_sdo, spi_sdo_oe;
    logic [5:0] reg_addr;
    logic       reg_wr, reg_rd;
    logic [7:0] reg_wdata, reg_rdata;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit finished = 0;

    logic [7:0] regmem [64];
    logic [7:0] expm   [64];
    logic [5:0] wlog_a [256];
    logic [7:0] wlog_d [256];
    int         wcount = 0;
    int         rcount = 0;
    logic [7:0] wbuf [16];
    logic [7:0] rbuf [16];
    bit         oe_bad;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_regslave uut (
        .clk(clk), .rst(rst), .cfg_three_wire(cfg_three_wire),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_sdi(spi_sdi),
        .spi_sdio_in(spi_sdio_in), .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata)
    );

    function automatic logic [7:0] init_val(input int i);
        return 8'(i * 13 + 5);
    endfunction

    // Register file model on the bus side
    assign reg_rdata = regmem[reg_addr];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 64; i++) regmem[i] <= init_val(i);
        end else begin
            if (reg_wr) begin
                regmem[reg_addr]    <= reg_wdata;
                wlog_a[wcount % 256] <= reg_addr;
                wlog_d[wcount % 256] <= reg_wdata;
                wcount <= wcount + 1;
            end
            if (reg_rd) rcount <= rcount + 1;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One SPI transaction; cut >= 0 limits the total number of bits
    task automatic xfer(input logic tw, input logic rd, input logic inc,
                        input logic [5:0] addr, input int n, input int cut);
        logic [7:0] cmd;
        int nbits;
        cmd = {rd, inc, addr};
        nbits = (cut < 0) ? 8 * (n + 1) : cut;
        oe_bad = 0;
        cfg_three_wire = tw;
        @(negedge clk);
        spi_cs_n = 0;
        wait_clk(HALF);
        for (int b = 0; b < nbits; b++) begin
            logic v;
            v = (b < 8) ? cmd[7-b] : wbuf[(b-8)/8][7-((b-8)%8)];
            spi_sclk = 0;
            if (tw) begin spi_sdio_in = v; spi_sdi = ~v; end
            else    begin spi_sdi = v; spi_sdio_in = ~v; end
            wait_clk(HALF);
            if (b >= 8) begin
                rbuf[(b-8)/8][7-((b-8)%8)] = spi_sdo;
                if (spi_sdo_oe !== rd) oe_bad = 1;
            end
            spi_sclk = 1;
            wait_clk(HALF);
        end
        spi_cs_n = 1;
        wait_clk(4 * HALF);
    endtask

    function automatic logic [5:0] step(input logic [5:0] a, input logic inc, input logic rd);
        if (!inc) return a;
        if (rd && a == 6'h2D) return 6'h28;
        return a + 6'd1;
    endfunction

    initial begin
        for (int i = 0; i < 64; i++) expm[i] = init_val(i);
        wait_clk(5);
        // R1: reset state
        check("R1 reset oe", spi_sdo_oe, 0);
        check("R1 reset wr", reg_wr, 0);
        check("R1 reset rd", reg_rd, 0);
        check("R1 reset addr", reg_addr, 0);
        rst = 0;
        wait_clk(5);

        // R1: clock toggles with chip select high
        begin
            int w0, r0;
            bit oe_seen;
            w0 = wcount; r0 = rcount; oe_seen = 0;
            for (int k = 0; k < 20; k++) begin
                spi_sclk = ~spi_sclk; spi_sdi = k[0];
                wait_clk(HALF);
                if (spi_sdo_oe) oe_seen = 1;
            end
            spi_sclk = 1;
            wait_clk(2 * HALF);
            check("R1 idle writes", wcount - w0, 0);
            check("R1 idle reads", rcount - r0, 0);
            check("R1 idle oe", oe_seen, 0);
        end

        // Vector table
        for (int v = 0; v < NV; v++) begin
            vec_t  e;
            logic [5:0] a;
            int    w0;
            string tag;
            e = VECS[v];
            tag = e.tw ? "R8" : (!e.inc ? "R5" : (e.rd ? "R7" : "R11"));
            a = e.addr;
            w0 = wcount;
            if (!e.rd) begin
                for (int k = 0; k < int'(e.n); k++) wbuf[k] = 8'(a * 7 + k + 8'h3C) ^ 8'(v);
                xfer(e.tw, 1'b0, e.inc, e.addr, int'(e.n), -1);
                check("R3 write count", wcount - w0, int'(e.n));
                for (int k = 0; k < int'(e.n); k++) begin
                    check({tag, " R6 write addr"}, wlog_a[(w0 + k) % 256], a);
                    check({tag, " R3 write data"}, wlog_d[(w0 + k) % 256], wbuf[k]);
                    expm[a] = wbuf[k];
                    a = step(a, e.inc, 1'b0);
                end
                check("R9 oe low during write", oe_bad, 0);
            end else begin
                xfer(e.tw, 1'b1, e.inc, e.addr, int'(e.n), -1);
                check("R3 no write on read", wcount - w0, 0);
                for (int k = 0; k < int'(e.n); k++) begin
                    check({tag, " R4 R6 read data"}, rbuf[k], expm[a]);
                    a = step(a, e.inc, 1'b1);
                end
                check("R9 oe high during read", oe_bad, 0);
            end
        end

        // R2: single-byte read from the top address
        xfer(1'b0, 1'b1, 1'b0, 6'h3F, 1, -1);
        check("R2 read 0x3F", rbuf[0], expm[6'h3F]);

        // R10: write cut after 5 data bits
        begin
            int w0;
            w0 = wcount;
            wbuf[0] = 8'h00;
            xfer(1'b0, 1'b0, 1'b1, 6'h10, 1, 13);
            check("R10 no partial write", wcount - w0, 0);
            xfer(1'b0, 1'b1, 1'b0, 6'h10, 1, -1);
            check("R10 register kept", rbuf[0], expm[6'h10]);
        end

        // R1: quiet after traffic
        check("R1 idle oe after traffic", spi_sdo_oe, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(negedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule